// File: doc/BRIEF.md
# Serial Slave Mode Timeout Monitor

This block sits beside the serial slave of a position sensor link and watches the clock line that the interface master drives. A free-running reference clock measures the time since the master clock last changed level. When that gap reaches a programmable limit, the block decides that the current communication mode has lapsed. It then raises a one-cycle timeout pulse and falls back to idle, with the data line released high for the next frame.

The master picks the mode: sensor data or register access. The slave only fixes the longest clock gap over which that mode is kept, so the limits also set the lowest master clock frequency that still works. Each mode has its own 2-bit limit code, and the mode input chooses which one applies. Register code 3 is not a legal setting. The block reports it as a configuration error and uses the longest register window in its place.

Top module: `mode_timeout_monitor`

## Requirements
- R1: In sensor mode (`reg_mode_i`=0), `sens_code_i` values 0, 1, 2 and 3 select a limit of 256, 32, 8 and 2 reference clock cycles.
- R2: In register mode (`reg_mode_i`=1), `reg_code_i` values 0, 1 and 2 select a limit of 2049, 513 and 67 reference clock cycles.
- R3: `cfg_err_o` is high exactly while `reg_code_i` is 3. In that case, register mode uses the 2049-cycle limit.
- R4: The raw `mclk_i` passes through a two-flop synchronizer. A level change is seen as an edge two reference cycles after it is sampled. Every edge, rising or falling, restarts the gap count at zero and makes the mode active.
- R5: While the mode is active, `timeout_o` is high for one cycle when the count of reference cycles without an edge reaches the selected limit. If an edge arrives in that same cycle, the edge takes precedence and no timeout occurs.
- R6: After a timeout, the block is idle: `line_idle_o`=1 and `mode_held_o`=0. While idle, `timeout_o` stays low until the next edge.
- R7: During and after reset, the count is zero, `line_idle_o`=1, `mode_held_o`=0 and `timeout_o`=0.
- R8: The limit is compared against the current code and mode on every cycle. If the code or mode changes to a limit at or below the elapsed count, a timeout fires on the next cycle with no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mclk_i | input | 1 | Master clock line, asynchronous |
| reg_mode_i | input | 1 | 1 = register access mode, 0 = sensor mode |
| sens_code_i | input | 2 | Sensor mode timeout code |
| reg_code_i | input | 2 | Register mode timeout code |
| timeout_o | output | 1 | One-cycle pulse when the mode lapses |
| line_idle_o | output | 1 | Slave is idle, data line high |
| mode_held_o | output | 1 | Selected mode is still retained |
| cfg_err_o | output | 1 | Forbidden register timeout code |

## Verification
Gaps just below, at and well past every limit in both modes separate an off-by-one limit from a correct one, and they also catch any swap between codes. Trains of rising and falling edges with one-cycle spacing check that both polarities restart the count and that an edge beats a coincident timeout. Changing the mode or code in the middle of a gap shows that the limit is re-evaluated on every cycle. Register code 3 shows both the error flag and the fallback to the longest window. A reset in the middle of a gap shows that idle is restored.

// File: rtl/mode_timeout_monitor.sv
module mode_timeout_monitor #(
  parameter int SENS_LIM0 = 256,
  parameter int SENS_LIM1 = 32,
  parameter int SENS_LIM2 = 8,
  parameter int SENS_LIM3 = 2,
  parameter int REG_LIM0  = 2049,
  parameter int REG_LIM1  = 513,
  parameter int REG_LIM2  = 67
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mclk_i,
  input  logic       reg_mode_i,
  input  logic [1:0] sens_code_i,
  input  logic [1:0] reg_code_i,
  output logic       timeout_o,
  output logic       line_idle_o,
  output logic       mode_held_o,
  output logic       cfg_err_o
);
  localparam int CW = $clog2(REG_LIM0 + 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          active_q;
  logic [CW-1:0] lim;
  logic          edge_seen;
  logic          hit;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], mclk_i};

  assign edge_seen = sync_q[1] ^ sync_q[2];
  assign cfg_err_o = (reg_code_i == 2'd3);

  always_comb begin
    if (reg_mode_i) begin
      case (reg_code_i)
        2'd1:    lim = CW'(REG_LIM1);
        2'd2:    lim = CW'(REG_LIM2);
        default: lim = CW'(REG_LIM0);
      endcase
    end else begin
      case (sens_code_i)
        2'd0:    lim = CW'(SENS_LIM0);
        2'd1:    lim = CW'(SENS_LIM1);
        2'd2:    lim = CW'(SENS_LIM2);
        default: lim = CW'(SENS_LIM3);
      endcase
    end
  end

  assign hit = active_q && !edge_seen && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (edge_seen) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (hit) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q    <= cnt_q + 1'b1;
    end

  assign timeout_o   = hit;
  assign line_idle_o = !active_q;
  assign mode_held_o = active_q;

  assert_single_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
  assert_idle_after_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> line_idle_o && !mode_held_o);
  assert_idle_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_idle_o) |-> $past(timeout_o));
  assert_edge_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_seen |=> (cnt_q == '0) && mode_held_o && !timeout_o);
  assert_nonzero_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> cnt_q != '0);
endmodule

// File: tb/test_mode_timeout_monitor.sv
module test_mode_timeout_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclk = 1'b0;
  logic reg_mode = 1'b0;
  logic [1:0] sens_code = 2'd0;
  logic [1:0] reg_code = 2'd0;
  logic timeout, line_idle, mode_held, cfg_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mode_timeout_monitor i_mode_timeout_monitor (
    .clk_i(clk), .rst_ni(rst_n), .mclk_i(mclk), .reg_mode_i(reg_mode),
    .sens_code_i(sens_code), .reg_code_i(reg_code),
    .timeout_o(timeout), .line_idle_o(line_idle), .mode_held_o(mode_held),
    .cfg_err_o(cfg_err));

  // Behavioural reference: sample history, gap counter, active flag.
  bit hist[$] = '{0, 0, 0};
  int gap = 0;
  bit act = 0;

  function automatic int limit_now();
    if (reg_mode) begin
      case (reg_code)
        2'd1: return 513;      // R2
        2'd2: return 67;       // R2
        default: return 2049;  // R2 code 0, R3 fallback
      endcase
    end
    case (sens_code)
      2'd0: return 256;        // R1
      2'd1: return 32;
      2'd2: return 8;
      default: return 2;
    endcase
  endfunction

  function automatic bit model_edge();
    return hist[1] != hist[2];  // R4: two sync stages, then change detect
  endfunction

  function automatic bit model_tmo();
    return act && !model_edge() && gap >= limit_now();  // R5, R8
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{0, 0, 0}; gap = 0; act = 0;  // R7
    end else begin
      if (model_edge()) begin gap = 0; act = 1; end
      else if (model_tmo()) act = 0;
      else if (act) gap++;
      hist.push_front(mclk);
      void'(hist.pop_back());
    end
  end

  task automatic cmp(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, got, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cmp(reg_mode ? "R2/R5 timeout" : "R1/R5 timeout", timeout, model_tmo());
    cmp("R6 line_idle", line_idle, !act);
    cmp("R6 mode_held", mode_held, act);
    cmp("R3 cfg_err", cfg_err, reg_code == 2'd3);
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tog_gap(int n);
    mclk = ~mclk;
    wait_cyc(n);
  endtask

  task automatic probe(int lim);
    tog_gap(1); tog_gap(1); tog_gap(lim - 1); tog_gap(lim); tog_gap(lim + 1);
    tog_gap(lim + 8);
  endtask

  initial begin
    wait_cyc(4);
    // R7: reset state
    checks++;
    if (timeout !== 0 || line_idle !== 1 || mode_held !== 0) begin
      failures++;
      $display("FAIL R7 reset state: actual=%b%b%b expected=011", timeout, line_idle, mode_held);
    end
    rst_n = 1'b1;
    wait_cyc(3);
    // R1 sensor table, both edge polarities (R4, R5, R6)
    reg_mode = 0;
    for (int c = 0; c < 4; c++) begin
      sens_code = 2'(c);
      probe(c == 0 ? 256 : c == 1 ? 32 : c == 2 ? 8 : 2);
    end
    // R2 register table
    reg_mode = 1;
    for (int c = 0; c < 3; c++) begin
      reg_code = 2'(c);
      probe(c == 0 ? 2049 : c == 1 ? 513 : 67);
    end
    // R3 forbidden code: flag and fallback
    reg_code = 2'd3;
    tog_gap(2048); tog_gap(2060);
    // R8 mid-gap reconfiguration
    reg_code = 2'd0;
    tog_gap(100);
    reg_mode = 0; sens_code = 2'd1;
    wait_cyc(5);
    sens_code = 2'd0;
    tog_gap(40);
    sens_code = 2'd2;
    wait_cyc(20);
    // R7 reset during active gap
    tog_gap(4);
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(20);
    tog_gap(30);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule